// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block takes one asynchronous serial line and turns each character on it into a parallel word. An internal tick runs at sixteen times the bit rate. The tick comes from a programmable clock divider, and its phase is reset on every start edge. The receiver uses these ticks to find the start bit, to reject short low glitches, and to sample every later bit in its middle. Four configuration inputs set the character length (5 to 9 bits), optional even or odd parity, and one or two stop bits.

Each received word goes into a small FIFO together with its own parity-error and framing-error flags. The consumer sees the word at the head of the FIFO while the valid output is high. It removes that word with a pop strobe. A character that arrives while the FIFO is full is thrown away and raises a sticky overrun flag. A separate strobe clears that flag.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, `rdValid` and `overrun` are low.
- R2: The line idles high. A falling edge begins a candidate start bit. The candidate is accepted only if the line stays low at every tick up to the eighth one. A low pulse shorter than half a bit period therefore produces no word.
- R3: Data bits arrive least significant bit first. `dataBits` selects 5 to 9 bits; values below 5 act as 5 and values above 9 act as 9. The word appears right-aligned in `rdData`, with the unused upper bits at zero.
- R4: When `parityEn` is high, one parity bit follows the data. `parityOdd`=0 expects the XOR of the data bits and the parity bit to be 0; `parityOdd`=1 expects it to be 1. A mismatch sets `rdParityErr` for that word. When `parityEn` is low, `rdParityErr` stays 0.
- R5: `twoStop` selects two stop bits (1) or one (0). If any stop bit samples low, `rdFrameErr` is set for that word.
- R6: One bit period equals 16 × `divisor` clock cycles, where a divisor of 0 acts as 1.
- R7: Tick timing is restarted on each start edge. Back-to-back frames whose bit period differs from the nominal by 1/32 are received correctly.
- R8: Words leave the FIFO in arrival order. `rdValid` is high while the FIFO holds a word. A one-cycle `popReq` removes the head word. The head word stays stable until it is popped.
- R9: A word that completes while the FIFO is full (and no pop happens in the same cycle) is dropped and sets `overrun`. `overrun` stays set until `clrOverrun` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Clock cycles per oversampling tick |
| dataBits | input | 4 | Character length, 5 to 9 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits |
| rxLine | input | 1 | Asynchronous serial input, idles high |
| popReq | input | 1 | Removes the head word from the FIFO |
| clrOverrun | input | 1 | Clears the sticky overrun flag |
| rdData | output | 9 | Head word, right-aligned |
| rdValid | output | 1 | FIFO holds at least one word |
| rdParityErr | output | 1 | Parity error of the head word |
| rdFrameErr | output | 1 | Framing error of the head word |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
The hardest conditions to reach are a full FIFO at the moment a word completes, and a bit clock that drifts close to the sampling margin. The bench reaches the first by sending five characters without popping. It then checks that the flag is set and that exactly the first four words come out, in order. For drift, it sends three frames back to back at a bit period of 33 clock cycles instead of 32. Without the restart on each start edge, the tick phase would slide across frame boundaries. A sweep over every length, parity and stop-bit combination, plus deliberate parity flips, bad stop bits and short low glitches, covers the flags and glitch rejection.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS   = 9;
  localparam int MIN_BITS   = 5;
  localparam int OVERSAMPLE = 16;
  localparam int CNT_W      = $clog2(OVERSAMPLE);
  localparam int HALF       = OVERSAMPLE / 2;

  typedef struct packed {
    logic tickRestart;
    logic sampleData;
    logic sampleParity;
    logic sampleStop;
    logic push;
  } srx_strobe_t;

  typedef struct packed {
    logic                perr;
    logic                ferr;
    logic [MAX_BITS-1:0] data;
  } rx_word_t;

  function automatic logic [3:0] clampBits(input logic [3:0] req);
    if (req < 4'(MIN_BITS)) return 4'(MIN_BITS);
    if (req > 4'(MAX_BITS)) return 4'(MAX_BITS);
    return req;
  endfunction
endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] lastCnt;

  assign lastCnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick    = !restart && (divCnt >= lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (restart)          divCnt <= '0;
    else if (divCnt >= lastCnt) divCnt <= '0;
    else                       divCnt <= divCnt + DIV_W'(1);
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        lineSync,
  input  logic        lineFall,
  input  logic [3:0]  dataBits,
  input  logic        parityEn,
  input  logic        twoStop,
  output srx_strobe_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} state_t;

  state_t           st, stNext;
  logic [CNT_W-1:0] tCnt, tNext;
  logic [3:0]       bitCnt, bNext;
  logic [3:0]       nBits;
  logic             atCentre;

  assign nBits    = clampBits(dataBits);
  assign atCentre = tick && (tCnt == CNT_W'(OVERSAMPLE - 1));

  always_comb begin
    stNext = st;
    tNext  = tCnt;
    bNext  = bitCnt;
    stb    = '0;
    if (st != S_IDLE && st != S_START && tick && !atCentre) tNext = tCnt + CNT_W'(1);
    unique case (st)
      S_IDLE: begin
        if (lineFall) begin
          stNext          = S_START;
          tNext           = '0;
          stb.tickRestart = 1'b1;
        end
      end
      S_START: begin
        if (tick) begin
          if (lineSync) stNext = S_IDLE;
          else if (tCnt == CNT_W'(HALF - 1)) begin
            stNext = S_DATA;
            tNext  = '0;
            bNext  = '0;
          end else tNext = tCnt + CNT_W'(1);
        end
      end
      S_DATA: begin
        if (atCentre) begin
          stb.sampleData = 1'b1;
          tNext          = '0;
          if (bitCnt == nBits - 4'd1) stNext = parityEn ? S_PAR : S_STOP1;
          else bNext = bitCnt + 4'd1;
        end
      end
      S_PAR: begin
        if (atCentre) begin
          stb.sampleParity = 1'b1;
          tNext            = '0;
          stNext           = S_STOP1;
        end
      end
      S_STOP1: begin
        if (atCentre) begin
          stb.sampleStop = 1'b1;
          tNext          = '0;
          if (twoStop) stNext = S_STOP2;
          else begin
            stb.push = 1'b1;
            stNext   = S_IDLE;
          end
        end
      end
      S_STOP2: begin
        if (atCentre) begin
          stb.sampleStop = 1'b1;
          stb.push       = 1'b1;
          tNext          = '0;
          stNext         = S_IDLE;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      tCnt   <= '0;
      bitCnt <= '0;
    end else begin
      st     <= stNext;
      tCnt   <= tNext;
      bitCnt <= bNext;
    end
  end
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  srx_strobe_t         stb,
  input  logic [3:0]          dataBits,
  input  logic                parityOdd,
  input  logic                popReq,
  input  logic                clrOverrun,
  output logic                lineSync,
  output logic                lineFall,
  output logic [MAX_BITS-1:0] rdData,
  output logic                rdValid,
  output logic                rdParityErr,
  output logic                rdFrameErr,
  output logic                overrun
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]          syncQ;
  logic                lineD;
  logic [MAX_BITS-1:0] shReg;
  logic                parAcc, perrQ, ferrQ;
  rx_word_t            pushWord, headWord;
  rx_word_t            mem [FIFO_DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    count;
  logic                full, doPop, doPush, drop;
  logic [3:0]          nBits;

  assign lineSync = syncQ[1];
  assign lineFall = lineD & ~lineSync;
  assign nBits    = clampBits(dataBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      lineD <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      lineD <= lineSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
      perrQ  <= 1'b0;
      ferrQ  <= 1'b0;
    end else if (stb.tickRestart) begin
      shReg  <= '0;
      parAcc <= 1'b0;
      perrQ  <= 1'b0;
      ferrQ  <= 1'b0;
    end else begin
      if (stb.sampleData) begin
        shReg  <= {lineSync, shReg[MAX_BITS-1:1]};
        parAcc <= parAcc ^ lineSync;
      end
      if (stb.sampleParity) perrQ <= parAcc ^ lineSync ^ parityOdd;
      if (stb.sampleStop)   ferrQ <= ferrQ | ~lineSync;
    end
  end

  always_comb begin
    pushWord.data = shReg >> (4'(MAX_BITS) - nBits);
    pushWord.perr = perrQ;
    pushWord.ferr = ferrQ | (stb.sampleStop & ~lineSync);
  end

  assign full   = (count == CNT_W'(FIFO_DEPTH));
  assign doPop  = popReq && (count != '0);
  assign doPush = stb.push && (!full || doPop);
  assign drop   = stb.push && full && !doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < FIFO_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushWord;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           overrun <= 1'b0;
    else if (drop)       overrun <= 1'b1;
    else if (clrOverrun) overrun <= 1'b0;
  end

  assign headWord    = mem[rdPtr];
  assign rdValid     = (count != '0);
  assign rdData      = headWord.data;
  assign rdParityErr = headWord.perr;
  assign rdFrameErr  = headWord.ferr;
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import srx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [3:0]       dataBits,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic             rxLine,
  input  logic             popReq,
  input  logic             clrOverrun,
  output logic [8:0]       rdData,
  output logic             rdValid,
  output logic             rdParityErr,
  output logic             rdFrameErr,
  output logic             overrun
);
  srx_strobe_t ctl;
  logic        tick, lineSync, lineFall;

  srx_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rstN(rstN), .restart(ctl.tickRestart), .divisor(divisor), .tick(tick)
  );

  srx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .lineSync(lineSync), .lineFall(lineFall),
    .dataBits(dataBits), .parityEn(parityEn), .twoStop(twoStop), .stb(ctl)
  );

  srx_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .stb(ctl), .dataBits(dataBits),
    .parityOdd(parityOdd), .popReq(popReq), .clrOverrun(clrOverrun),
    .lineSync(lineSync), .lineFall(lineFall), .rdData(rdData), .rdValid(rdValid),
    .rdParityErr(rdParityErr), .rdFrameErr(rdFrameErr), .overrun(overrun)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       push,
  input logic       sampleData,
  input logic       sampleParity,
  input logic       sampleStop,
  input logic       popReq,
  input logic       clrOverrun,
  input logic       rdValid,
  input logic [8:0] rdData,
  input logic       overrun
);
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(push));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !clrOverrun |=> overrun);

  p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrOverrun && !push |=> !overrun);

  p_push_fills_r8: assert property (@(posedge clk) disable iff (!rstN)
    push |=> rdValid);

  p_head_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !popReq |=> rdValid && $stable(rdData));

  p_one_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleData, sampleParity, sampleStop}));

  p_push_on_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    push |-> sampleStop);
endmodule

bind serial_rx_top srx_checker chk_i (
  .clk(clk), .rstN(rstN), .push(ctl.push), .sampleData(ctl.sampleData),
  .sampleParity(ctl.sampleParity), .sampleStop(ctl.sampleStop), .popReq(popReq),
  .clrOverrun(clrOverrun), .rdValid(rdValid), .rdData(rdData), .overrun(overrun)
);

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic [3:0]  dataBits = 4'd8;
  logic        parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic        rxLine = 1'b1, popReq = 1'b0, clrOverrun = 1'b0;
  logic [8:0]  rdData;
  logic        rdValid, rdParityErr, rdFrameErr, overrun;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_top dut_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .dataBits(dataBits), .parityEn(parityEn),
    .parityOdd(parityOdd), .twoStop(twoStop), .rxLine(rxLine), .popReq(popReq),
    .clrOverrun(clrOverrun), .rdData(rdData), .rdValid(rdValid),
    .rdParityErr(rdParityErr), .rdFrameErr(rdFrameErr), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int clks);
    rxLine = b;
    repeat (clks) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic sendFrame(input logic [8:0] d, input int nb, input int pm, input bit flipPar,
                           input logic [1:0] badStop, input int stops, input int clks);
    logic [8:0] m;
    logic p;
    m = 9'((1 << nb) - 1);
    sendBit(1'b0, clks);
    for (int i = 0; i < nb; i++) sendBit(d[i], clks);
    if (pm != 0) begin
      p = ^(d & m);
      if (pm == 2) p = ~p;
      if (flipPar) p = ~p;
      sendBit(p, clks);
    end
    for (int s = 0; s < stops; s++) sendBit(~badStop[s], clks);
  endtask

  task automatic setCfg(input int nb, input int pm, input int stops);
    dataBits  = 4'(nb);
    parityEn  = (pm != 0);
    parityOdd = (pm == 2);
    twoStop   = (stops == 2);
  endtask

  task automatic popCheck(input logic [8:0] expD, input bit ep, input bit ef, input string req);
    chk(rdValid == 1'b1, req, "rdValid", int'(rdValid), 1);
    chk(rdData == expD, req, "rdData", int'(rdData), int'(expD));
    chk(rdParityErr == ep, "R4", "rdParityErr", int'(rdParityErr), int'(ep));
    chk(rdFrameErr == ef, "R5", "rdFrameErr", int'(rdFrameErr), int'(ef));
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [8:0] d, m;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdValid == 1'b0, "R1", "rdValid", int'(rdValid), 0);
    chk(overrun == 1'b0, "R1", "overrun", int'(overrun), 0);

    // R3/R4/R5 sweep over every format at divisor 2 (32 clocks per bit)
    for (int nb = 5; nb <= 9; nb++)
      for (int pm = 0; pm <= 2; pm++)
        for (int st = 1; st <= 2; st++) begin
          setCfg(nb, pm, st);
          for (int k = 0; k < 4; k++) begin
            m = 9'((1 << nb) - 1);
            case (k)
              0: d = 9'h000;
              1: d = 9'h1FF;
              2: d = 9'h155;
              default: d = 9'((nb * 37 + pm * 11 + st * 5) % 512);
            endcase
            sendFrame(d, nb, pm, 1'b0, 2'b00, st, 32);
            sendBit(1'b1, 32);
            popCheck(d & m, 1'b0, 1'b0, "R3");
          end
        end

    // R4 parity errors, even and odd
    setCfg(8, 1, 1);
    sendFrame(9'h0A5, 8, 1, 1'b1, 2'b00, 1, 32);
    sendBit(1'b1, 32);
    popCheck(9'h0A5, 1'b1, 1'b0, "R4");
    setCfg(7, 2, 1);
    sendFrame(9'h03C, 7, 2, 1'b1, 2'b00, 1, 32);
    sendBit(1'b1, 32);
    popCheck(9'h03C, 1'b1, 1'b0, "R4");

    // R5 framing errors on first and second stop bit
    setCfg(8, 1, 1);
    sendFrame(9'h05A, 8, 1, 1'b0, 2'b01, 1, 32);
    sendBit(1'b1, 32);
    popCheck(9'h05A, 1'b0, 1'b1, "R5");
    setCfg(8, 0, 2);
    sendFrame(9'h0C3, 8, 0, 1'b0, 2'b10, 2, 32);
    sendBit(1'b1, 32);
    popCheck(9'h0C3, 1'b0, 1'b1, "R5");

    // R2 glitch rejection: low pulses of 6 and 5 ticks
    setCfg(8, 0, 1);
    sendBit(1'b0, 12);
    sendBit(1'b1, 100);
    sendBit(1'b0, 10);
    sendBit(1'b1, 400);
    chk(rdValid == 1'b0, "R2", "rdValid after glitch", int'(rdValid), 0);
    sendFrame(9'h081, 8, 0, 1'b0, 2'b00, 1, 32);
    sendBit(1'b1, 32);
    popCheck(9'h081, 1'b0, 1'b0, "R2");

    // R3 clamp: dataBits 12 behaves as 9
    dataBits = 4'd12;
    sendFrame(9'h1A3, 9, 0, 1'b0, 2'b00, 1, 32);
    sendBit(1'b1, 32);
    popCheck(9'h1A3, 1'b0, 1'b0, "R3");

    // R6 divisor 3: 48 clocks per bit
    divisor = 16'd3;
    setCfg(7, 2, 2);
    sendFrame(9'h055, 7, 2, 1'b0, 2'b00, 2, 48);
    sendBit(1'b1, 48);
    popCheck(9'h055, 1'b0, 1'b0, "R6");
    sendFrame(9'h02A, 7, 2, 1'b0, 2'b00, 2, 48);
    sendBit(1'b1, 48);
    popCheck(9'h02A, 1'b0, 1'b0, "R6");
    divisor = 16'd2;

    // R7 back-to-back frames at a slow bit period
    setCfg(8, 0, 1);
    sendFrame(9'h0F0, 8, 0, 1'b0, 2'b00, 1, 33);
    sendFrame(9'h00F, 8, 0, 1'b0, 2'b00, 1, 33);
    sendFrame(9'h099, 8, 0, 1'b0, 2'b00, 1, 33);
    sendBit(1'b1, 64);
    popCheck(9'h0F0, 1'b0, 1'b0, "R7");
    popCheck(9'h00F, 1'b0, 1'b0, "R7");
    popCheck(9'h099, 1'b0, 1'b0, "R7");

    // R8/R9 fill FIFO and overflow by one
    for (int k = 0; k < 5; k++) begin
      sendFrame(9'(k + 16), 8, 0, 1'b0, 2'b00, 1, 32);
      sendBit(1'b1, 32);
    end
    chk(overrun == 1'b1, "R9", "overrun set", int'(overrun), 1);
    sendBit(1'b1, 20);
    chk(overrun == 1'b1, "R9", "overrun sticky", int'(overrun), 1);
    clrOverrun = 1'b1;
    @(negedge clk);
    clrOverrun = 1'b0;
    chk(overrun == 1'b0, "R9", "overrun cleared", int'(overrun), 0);
    for (int k = 0; k < 4; k++) popCheck(9'(k + 16), 1'b0, 1'b0, "R8");
    chk(rdValid == 1'b0, "R9", "dropped word absent", int'(rdValid), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule